// File: doc/BRIEF.md
# Debug Status Register with Deferred Error Exceptions

This block is the debug control and status word of a 64-bit processor core. It records the reason a debug exception was entered, tracks entry into and exit from debug mode, and keeps the single-step enable and a few control bits that debug software may write. It also holds back imprecise error exceptions while an inhibit flag is set. The imprecise errors are fetch bus errors, data bus errors, cache errors and machine checks. Each one waits as a pending bit and is released as a request once the inhibit flag drops.

The core pipeline drives single-cycle event pulses into the block. Software reads the whole register at any time and writes it through a one-cycle write strobe. The upper 32 bits of the register and bits 31:30 always read as zero. The remaining fields use the layout given in the requirements. A version code, a "no single step" flag and a "no debug segment" flag are fixed by parameters.

Top module: `dbg_status_reg`

## Requirements
- R1: After reset every stored bit reads 0. The only bits that read 1 are the constant fields: bits 29:27 hold VER, bit 21 holds NO_DSEG, and bit 11 holds NO_STEP.
- R2: A debug entry pulse sets debug mode (bit 8, also `dbg_mode_o`) and the inhibit flag (bit 12). The same pulse captures `dslot_i` into bit 9, `doze_i` into bit 17 and `halt_i` into bit 18.
- R3: A debug return pulse, when no debug entry pulse comes in the same cycle, clears debug mode and the inhibit flag.
- R4: The cause bits 7:0 are sticky. They are set by `cause_ev_i`, with these bit meanings: 0 breakpoint instruction, 1 single step, 2 debug interrupt, 3 instruction break, 4 precise load break, 5 precise store break, 6 imprecise load break, 7 imprecise store break.
- R5: An exception taken in debug mode clears all eight cause bits, except any cause event in the same cycle. It loads `dm_code_i` into bits 26:22, where code 30 means cache error and code 9 means breakpoint instruction, and it sets the inhibit flag.
- R6: The pending bits 16:13 are set in two ways: by `err_ev_i`, or by a software write of 1 to the bit. Bit 13 is fetch bus error, 14 data bus error, 15 cache error and 16 machine check. A software write of 0 has no effect on a pending bit.
- R7: While the inhibit flag is 1, `err_req_o` stays zero, whatever is pending.
- R8: While the inhibit flag is 0, `err_req_o` is one-hot on the highest-priority pending error. The priority order is machine check, cache error, data bus error, fetch bus error. The bit order of `err_req_o` matches bits 13..16. The granted pending bit clears at the next edge, so several pending errors come out one per cycle.
- R9: Bit 10 is the single-step enable and drives `step_en_o`; software writes it. When NO_STEP is 1, the bit is fixed at 0.
- R10: Software writes never change debug mode, delay slot, doze, halt, cause bits, exception code, version or the two capability flags. Bits 19 and 20 are read/write control bits.
- R11: A software write changes the inhibit flag only while debug mode is 1.
- R12: Bits 63:30 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_entry_i | input | 1 | Debug exception taken |
| dslot_i | input | 1 | Faulting instruction sat in a branch delay slot |
| doze_i | input | 1 | Core was in low-power state at entry |
| halt_i | input | 1 | Bus clock was stopped at entry |
| dm_exc_i | input | 1 | Exception taken while in debug mode |
| dm_code_i | input | 5 | Cause code of that exception |
| dret_i | input | 1 | Debug return executed |
| cause_ev_i | input | 8 | Debug cause event pulses |
| err_ev_i | input | 4 | Imprecise error events |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | DATA_W | Software write data |
| rd_data_o | output | DATA_W | Register value |
| dbg_mode_o | output | 1 | Debug mode active |
| step_en_o | output | 1 | Single-step enable |
| err_req_o | output | 4 | Error exception requests |

## Verification
The bench builds two copies of the block. Both use VER=2 and NO_DSEG=1, so that a constant 1 shows up in the read value. One copy has NO_STEP=0, and there software writes to the step enable take effect. The other has NO_STEP=1, and the step bit must stay 0 for the same writes. This pair covers both generate branches of the step logic. Directed steps drain all four pending errors to show the priority order. Random stimulus then mixes entries, returns, exceptions in debug mode and writes that overlap on the same cycles.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int NUM_CAUSE = 8;
  localparam int NUM_ERR   = 4;
  localparam int CODE_W    = 5;
  localparam int VER_W     = 3;

  localparam int CAUSE_LSB = 0;
  localparam int B_MODE    = 8;
  localparam int B_DSLOT   = 9;
  localparam int B_STEP    = 10;
  localparam int B_NOSTEP  = 11;
  localparam int B_INH     = 12;
  localparam int PEND_LSB  = 13;
  localparam int B_DOZE    = 17;
  localparam int B_HALT    = 18;
  localparam int B_CNT     = 19;
  localparam int B_LDST    = 20;
  localparam int B_NODSEG  = 21;
  localparam int CODE_LSB  = 22;
  localparam int VER_LSB   = 27;
  localparam int LOW_W     = 32;

  typedef enum logic [1:0] {
    ERR_FETCH = 2'd0,
    ERR_DBUS  = 2'd1,
    ERR_CACHE = 2'd2,
    ERR_MCHK  = 2'd3
  } err_idx_e;
endpackage

// File: rtl/dsr_cause.sv
module dsr_cause
  import dsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] cause_ev_i,
  input  logic                 dm_exc_i,
  input  logic [CODE_W-1:0]    dm_code_i,
  output logic [NUM_CAUSE-1:0] cause_o,
  output logic [CODE_W-1:0]    code_o
);
  logic [NUM_CAUSE-1:0] cause_q, cause_d;
  logic                 cause_en;
  logic [CODE_W-1:0]    code_q;

  always_comb begin
    cause_en = dm_exc_i | (|cause_ev_i);
    if (dm_exc_i) cause_d = cause_ev_i;
    else          cause_d = cause_q | cause_ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      code_q  <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (dm_exc_i) code_q  <= dm_code_i;
    end
  end

  assign cause_o = cause_q;
  assign code_o  = code_q;

  // R5
  cause_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_exc_i && cause_ev_i == '0) |=> cause_q == '0);
  // R4
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dm_exc_i |=> (cause_q & $past(cause_q)) == $past(cause_q));
endmodule

// File: rtl/dsr_defer.sv
module dsr_defer
  import dsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_inh_i,
  input  logic               dret_i,
  input  logic               sw_inh_wr_i,
  input  logic               sw_inh_val_i,
  input  logic [NUM_ERR-1:0] sw_pend_i,
  input  logic [NUM_ERR-1:0] err_ev_i,
  output logic               inh_o,
  output logic [NUM_ERR-1:0] pend_o,
  output logic [NUM_ERR-1:0] req_o
);
  logic               inh_q, inh_d, inh_en;
  logic [NUM_ERR-1:0] pend_q;
  logic [NUM_ERR-1:0] grant;

  always_comb begin
    inh_en = set_inh_i | dret_i | sw_inh_wr_i;
    if (set_inh_i)   inh_d = 1'b1;
    else if (dret_i) inh_d = 1'b0;
    else             inh_d = sw_inh_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inh_q <= 1'b0;
    else if (inh_en) inh_q <= inh_d;
  end

  // fixed priority: the highest index wins
  always_comb begin
    grant = '0;
    for (int i = 0; i < NUM_ERR; i++) begin
      if (pend_q[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign req_o = inh_q ? '0 : grant;

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_pend
    logic pend_d, pend_en;
    always_comb begin
      pend_en = req_o[g] | err_ev_i[g] | sw_pend_i[g];
      pend_d  = err_ev_i[g] | sw_pend_i[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q[g] <= 1'b0;
      else if (pend_en) pend_q[g] <= pend_d;
    end

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o[g] && !err_ev_i[g] && !sw_pend_i[g]) |=> !pend_q[g]);
    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ev_i[g] || sw_pend_i[g]) |=> pend_q[g]);
  end

  assign inh_o  = inh_q;
  assign pend_o = pend_q;

  // R8
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_o));
  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_inh_i |=> req_o == '0);
endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl #(
  parameter bit NO_STEP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic entry_i,
  input  logic dret_i,
  input  logic dslot_i,
  input  logic doze_i,
  input  logic halt_i,
  input  logic wr_en_i,
  input  logic wr_step_i,
  input  logic wr_cnt_i,
  input  logic wr_ldst_i,
  output logic mode_o,
  output logic dslot_o,
  output logic doze_o,
  output logic halt_o,
  output logic step_o,
  output logic cnt_o,
  output logic ldst_o
);
  logic mode_q, mode_d, mode_en;
  logic dslot_q, doze_q, halt_q, cnt_q, ldst_q;

  always_comb begin
    mode_en = entry_i | dret_i;
    mode_d  = entry_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      dslot_q <= 1'b0;
      doze_q  <= 1'b0;
      halt_q  <= 1'b0;
      cnt_q   <= 1'b0;
      ldst_q  <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (entry_i) begin
        dslot_q <= dslot_i;
        doze_q  <= doze_i;
        halt_q  <= halt_i;
      end
      if (wr_en_i) begin
        cnt_q  <= wr_cnt_i;
        ldst_q <= wr_ldst_i;
      end
    end
  end

  if (NO_STEP) begin : g_nostep
    assign step_o = 1'b0;
  end else begin : g_step
    logic step_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       step_q <= 1'b0;
      else if (wr_en_i) step_q <= wr_step_i;
    end
    assign step_o = step_q;

    // R9
    step_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> step_q == $past(wr_step_i));
  end

  assign mode_o  = mode_q;
  assign dslot_o = dslot_q;
  assign doze_o  = doze_q;
  assign halt_o  = halt_q;
  assign cnt_o   = cnt_q;
  assign ldst_o  = ldst_q;

  // R3
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dret_i && !entry_i) |=> !mode_q);
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dsr_pkg::*;
#(
  parameter int         DATA_W  = 64,
  parameter logic [2:0] VER     = 3'd2,
  parameter bit         NO_STEP = 1'b0,
  parameter bit         NO_DSEG = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbg_entry_i,
  input  logic                 dslot_i,
  input  logic                 doze_i,
  input  logic                 halt_i,
  input  logic                 dm_exc_i,
  input  logic [CODE_W-1:0]    dm_code_i,
  input  logic                 dret_i,
  input  logic [NUM_CAUSE-1:0] cause_ev_i,
  input  logic [NUM_ERR-1:0]   err_ev_i,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 dbg_mode_o,
  output logic                 step_en_o,
  output logic [NUM_ERR-1:0]   err_req_o
);
  localparam int HI_W = DATA_W - LOW_W;

  logic [NUM_CAUSE-1:0] cause;
  logic [CODE_W-1:0]    code;
  logic                 inh;
  logic [NUM_ERR-1:0]   pend;
  logic [NUM_ERR-1:0]   sw_pend;
  logic                 mode, dslot, doze, halt, step, cnt, ldst;
  logic [LOW_W-1:0]     low_word;

  assign sw_pend = wr_en_i ? wr_data_i[PEND_LSB +: NUM_ERR] : '0;

  dsr_cause u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .cause_ev_i (cause_ev_i),
    .dm_exc_i   (dm_exc_i),
    .dm_code_i  (dm_code_i),
    .cause_o    (cause),
    .code_o     (code)
  );

  dsr_defer u_defer (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_inh_i    (dbg_entry_i | dm_exc_i),
    .dret_i       (dret_i),
    .sw_inh_wr_i  (wr_en_i & mode),
    .sw_inh_val_i (wr_data_i[B_INH]),
    .sw_pend_i    (sw_pend),
    .err_ev_i     (err_ev_i),
    .inh_o        (inh),
    .pend_o       (pend),
    .req_o        (err_req_o)
  );

  dsr_ctrl #(.NO_STEP(NO_STEP)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_i   (dbg_entry_i),
    .dret_i    (dret_i),
    .dslot_i   (dslot_i),
    .doze_i    (doze_i),
    .halt_i    (halt_i),
    .wr_en_i   (wr_en_i),
    .wr_step_i (wr_data_i[B_STEP]),
    .wr_cnt_i  (wr_data_i[B_CNT]),
    .wr_ldst_i (wr_data_i[B_LDST]),
    .mode_o    (mode),
    .dslot_o   (dslot),
    .doze_o    (doze),
    .halt_o    (halt),
    .step_o    (step),
    .cnt_o     (cnt),
    .ldst_o    (ldst)
  );

  always_comb begin
    low_word                          = '0;
    low_word[CAUSE_LSB +: NUM_CAUSE]  = cause;
    low_word[B_MODE]                  = mode;
    low_word[B_DSLOT]                 = dslot;
    low_word[B_STEP]                  = step;
    low_word[B_NOSTEP]                = NO_STEP;
    low_word[B_INH]                   = inh;
    low_word[PEND_LSB +: NUM_ERR]     = pend;
    low_word[B_DOZE]                  = doze;
    low_word[B_HALT]                  = halt;
    low_word[B_CNT]                   = cnt;
    low_word[B_LDST]                  = ldst;
    low_word[B_NODSEG]                = NO_DSEG;
    low_word[CODE_LSB +: CODE_W]      = code;
    low_word[VER_LSB +: VER_W]        = VER;
  end

  assign rd_data_o  = {{HI_W{1'b0}}, low_word};
  assign dbg_mode_o = mode;
  assign step_en_o  = step;

  // R2
  entry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry_i |=> (dbg_mode_o && rd_data_o[B_INH]));
  // R11
  inh_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_mode_o && !dbg_entry_i && !dm_exc_i && !dret_i) |=> $stable(rd_data_o[B_INH]));
endmodule

// File: tb/test_dbg_status_reg.sv
module test_dbg_status_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        entry, dslot, doze, halt, dm_exc, dret, wr_en;
  logic [4:0]  dm_code;
  logic [7:0]  cause_ev;
  logic [3:0]  err_ev;
  logic [63:0] wr_data;
  logic [63:0] rd, rd2;
  logic        mode, mode2, step, step2;
  logic [3:0]  req, req2;

  int n_chk  = 0;
  int n_fail = 0;

  // model state
  logic [7:0] m_cause;
  logic [4:0] m_code;
  logic [3:0] m_pend;
  logic       m_mode, m_dslot, m_doze, m_halt, m_step, m_inh, m_cnt, m_ldst;

  always #5 clk = ~clk;

  dbg_status_reg #(.DATA_W(64), .VER(3'd2), .NO_STEP(1'b0), .NO_DSEG(1'b1)) i_dbg_status_reg (
    .clk(clk), .rst_n(rst_n), .dbg_entry_i(entry), .dslot_i(dslot), .doze_i(doze),
    .halt_i(halt), .dm_exc_i(dm_exc), .dm_code_i(dm_code), .dret_i(dret),
    .cause_ev_i(cause_ev), .err_ev_i(err_ev), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd), .dbg_mode_o(mode), .step_en_o(step), .err_req_o(req));

  dbg_status_reg #(.DATA_W(64), .VER(3'd2), .NO_STEP(1'b1), .NO_DSEG(1'b1)) i_dbg_status_reg_nostep (
    .clk(clk), .rst_n(rst_n), .dbg_entry_i(entry), .dslot_i(dslot), .doze_i(doze),
    .halt_i(halt), .dm_exc_i(dm_exc), .dm_code_i(dm_code), .dret_i(dret),
    .cause_ev_i(cause_ev), .err_ev_i(err_ev), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd2), .dbg_mode_o(mode2), .step_en_o(step2), .err_req_o(req2));

  function automatic logic [63:0] exp_rd();
    logic [31:0] w;
    w        = '0;
    w[7:0]   = m_cause;
    w[8]     = m_mode;
    w[9]     = m_dslot;
    w[10]    = m_step;
    w[12]    = m_inh;
    w[16:13] = m_pend;
    w[17]    = m_doze;
    w[18]    = m_halt;
    w[19]    = m_cnt;
    w[20]    = m_ldst;
    w[21]    = 1'b1;
    w[26:22] = m_code;
    w[29:27] = 3'd2;
    return {32'h0, w};
  endfunction

  function automatic logic [3:0] exp_req();
    logic [3:0] r;
    r = '0;
    if (!m_inh) begin
      if      (m_pend[3]) r = 4'b1000;
      else if (m_pend[2]) r = 4'b0100;
      else if (m_pend[1]) r = 4'b0010;
      else if (m_pend[0]) r = 4'b0001;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic idle_inputs();
    entry = 0; dslot = 0; doze = 0; halt = 0; dm_exc = 0; dm_code = '0;
    dret = 0; cause_ev = '0; err_ev = '0; wr_en = 0; wr_data = '0;
  endtask

  task automatic model_reset();
    m_cause = '0; m_code = '0; m_pend = '0; m_mode = 0; m_dslot = 0;
    m_doze = 0; m_halt = 0; m_step = 0; m_inh = 0; m_cnt = 0; m_ldst = 0;
  endtask

  // advance one clock with the inputs currently driven, then compare at the negedge
  task automatic cyc(input string tag);
    logic [3:0] n_pend;
    logic [7:0] n_cause;
    logic       n_inh;
    n_pend  = (m_pend & ~exp_req()) | err_ev | (wr_en ? wr_data[16:13] : 4'h0);
    n_cause = dm_exc ? cause_ev : (m_cause | cause_ev);
    if (entry || dm_exc)    n_inh = 1'b1;
    else if (dret)          n_inh = 1'b0;
    else if (wr_en && m_mode) n_inh = wr_data[12];
    else                    n_inh = m_inh;
    @(posedge clk);
    m_pend  = n_pend;
    m_cause = n_cause;
    m_inh   = n_inh;
    if (dm_exc) m_code = dm_code;
    if (entry) begin
      m_mode = 1'b1; m_dslot = dslot; m_doze = doze; m_halt = halt;
    end else if (dret) begin
      m_mode = 1'b0;
    end
    if (wr_en) begin
      m_step = wr_data[10]; m_cnt = wr_data[19]; m_ldst = wr_data[20];
    end
    @(negedge clk);
    idle_inputs();
    check({tag, " rd"},   rd,   exp_rd());
    check({tag, " req"},  {60'h0, req}, {60'h0, exp_req()});
    check({tag, " mode"}, {63'h0, mode}, {63'h0, m_mode});
    check({tag, " step"}, {63'h0, step}, {63'h0, m_step});
    check("R9 nostep", {63'h0, step2 | rd2[10]}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset value: version 2 at 29:27, no-dseg at 21
    check("R1 reset", rd, 64'h0000_0000_1020_0000);
    check("R1 reset nostep", rd2, 64'h0000_0000_1020_0800);
    check("R1 req", {60'h0, req}, 64'h0);

    cause_ev = 8'h05; cyc("R4");
    check("R4 bits", {56'h0, rd[7:0]}, 64'h05);
    cause_ev = 8'h80; cyc("R4");
    check("R4 sticky", {56'h0, rd[7:0]}, 64'h85);

    entry = 1; dslot = 1; doze = 1; halt = 0; cyc("R2");
    check("R2 mode/inh/slot/doze", {60'h0, rd[12], rd[9], rd[8], rd[17]}, 64'hF);

    err_ev = 4'b0001; cyc("R6");
    check("R7 held", {60'h0, req}, 64'h0);
    wr_en = 1; wr_data = 64'h1 << 12; wr_data[16] = 1; cyc("R6");
    check("R6 sw set", {60'h0, rd[16:13]}, 64'h9);
    wr_en = 1; wr_data = 64'h1 << 12; cyc("R6");
    check("R6 write 0 ignored", {60'h0, rd[16:13]}, 64'h9);

    wr_en = 1; wr_data = '1; cyc("R10");
    check("R12 upper", {32'h0, rd[63:30], 30'h0}, 64'h0);
    check("R10 ro kept", {59'h0, rd[8], rd[9], rd[17], rd[18], rd[21]}, 64'h1D);
    check("R9 step set", {63'h0, step}, 64'h1);
    check("R7 held all", {60'h0, req}, 64'h0);

    dm_exc = 1; dm_code = 5'd30; cyc("R5");
    check("R5 wipe+code", {32'h0, rd[26:22], 19'h0, rd[7:0]}, {32'h0, 5'd30, 27'h0});
    check("R5 inh", {63'h0, rd[12]}, 64'h1);

    dret = 1; cyc("R3");
    check("R3 exit", {62'h0, rd[8], rd[12]}, 64'h0);
    check("R8 mchk first", {60'h0, req}, 64'h8);
    cyc("R8"); check("R8 cache", {60'h0, req}, 64'h4);
    cyc("R8"); check("R8 dbus",  {60'h0, req}, 64'h2);
    cyc("R8"); check("R8 fetch", {60'h0, req}, 64'h1);
    cyc("R8"); check("R8 drained", {60'h0, req, rd[16:13]}, 64'h0);

    wr_en = 1; wr_data = 64'h1 << 12; cyc("R11");
    check("R11 locked", {63'h0, rd[12]}, 64'h0);

    for (int k = 0; k < 3000; k++) begin
      entry    = ($urandom % 16) == 0;
      dslot    = $urandom % 2;
      doze     = $urandom % 2;
      halt     = $urandom % 2;
      dret     = ($urandom % 14) == 0;
      dm_exc   = ($urandom % 18) == 0;
      dm_code  = 5'($urandom);
      cause_ev = (($urandom % 6) == 0) ? 8'($urandom) : 8'h0;
      err_ev   = (($urandom % 5) == 0) ? 4'($urandom) : 4'h0;
      wr_en    = ($urandom % 8) == 0;
      wr_data  = {$urandom, $urandom};
      cyc("R10 random");
    end
    finish_up();
  end
endmodule